// File: doc/BRIEF.md
# Paged Address Translator with Protection

This block sits between a processor and its DRAM. It takes a 26-bit logical address and produces a physical DRAM address. The mapping comes from a table with one entry per physical page. Each entry holds a logical page number, a valid flag and a two-bit protection level. A lookup compares the presented logical page against every valid entry at once. The index of the matching entry becomes the physical page number. That number is joined with the offset inside the page, and the result is registered. Software programs the table by writing one data word. That word carries the physical page, the logical page, the protection level and controller-select bits, and how those fields are laid out depends on the current page size.

The region whose address bit 25 is set bypasses translation. Only the supervisor may reach it. After reset, a boot-ROM overlay is active: logical reads are steered to ROM and logical writes are dropped. The overlay ends at the first table write or the first access to the direct region. Any access fault raises a sticky abort line, and that line stays high until the supervisor line is written again. The page size, the OS-mode bit and the supervisor value are provided from outside as plain inputs.

Top module: `page_xlate`

## Requirements
- R1: `page_size` selects the page size: code 0 is 4 KB, code 1 is 8 KB, code 2 is 16 KB and code 3 is 32 KB. A translated access returns `out_phys` equal to `ppn * size + (acc_addr mod size)`. The logical page is `acc_addr[24:0] / size`.
- R2: An entry write `ent_data` is decoded as follows.
  - Protection is taken from bits 9:8.
  - The logical page is bits 11:10 placed on top of the upper bits. For size codes 0 to 3, these upper bits are bits 22:12, 22:13, 22:14 and 22:15.
  - The physical page is decoded per size code:
    - Code 0: bits 6:0 as they are.
    - Code 1: {bit0, bits 6:1}.
    - Code 2: {bits 1:0, bits 6:2}.
    - Code 3: {bit1, bit2, bit0, bits 6:3}.
- R3: An entry write only takes effect when its select value equals parameter `CTRL_ID`. The select value is {0, bit7} for size code 0 and {bit12, bit7} for the other codes. A write with a different select value leaves the table unchanged.
- R4: Writing an entry replaces that physical page's previous mapping. It also invalidates any other entry that holds the same logical page. As a result, a logical page never matches two entries.
- R5: While the stored supervisor value is 1, every mapped page can be read and written, whatever its protection level.
- R6: While the supervisor value is 0, access depends on the protection level:
  - Level 0 allows read and write.
  - Level 1 allows read, and also allows write when `os_mode` is 1.
  - Levels 2 and 3 allow only reads, and only when `os_mode` is 1.
- R7: An access to an unmapped logical page, or one that breaks protection, sets `abort` one cycle later. `abort` stays set until `sup_we` is pulsed, which also loads `sup_val`.
- R8: After reset, the following hold:
  - No entry is valid.
  - The overlay is active.
  - The supervisor value is 1.
  - `abort`, `out_valid`, `out_hit`, `out_rom` and `out_phys` are all 0.
- R9: While the overlay is active, a logical read (bit 25 clear) returns `out_rom`=1 with `out_phys` = `acc_addr[21:0]`. A logical write returns `out_hit`=0 and `out_rom`=0 and does not raise `abort`.
- R10: Any entry write ends the overlay, as does any access with bit 25 set. An access with bit 25 set gives `out_hit`=1 and `out_phys` = `acc_addr[21:0]` when the supervisor value is 1; otherwise it aborts.
- R11: The results of an access appear on the outputs in the cycle after `acc_valid` is sampled, together with a one-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_addr | input | 26 | Logical address (bit 25 selects the direct region) |
| sup_we | input | 1 | Strobe that writes the supervisor line and clears abort |
| sup_val | input | 1 | New supervisor value |
| os_mode | input | 1 | OS-mode privilege bit |
| page_size | input | 2 | Page size code |
| ent_we | input | 1 | Table entry write strobe |
| ent_data | input | 23 | Entry write word |
| out_valid | output | 1 | Result pulse |
| out_hit | output | 1 | Access granted, `out_phys` valid |
| out_rom | output | 1 | Read redirected to boot ROM |
| out_phys | output | 22 | Physical address |
| abort | output | 1 | Sticky access fault |

## Verification
The checker assumes that `acc_valid` is held low during reset. It also assumes that a `sup_we` pulse is never given in the same cycle as a faulting access, because the abort-clear property depends on that separation. The bench drives each request in a cycle of its own, and never overlaps a supervisor write with an access. It also holds `page_size` and `os_mode` stable across each access. Random entry words keep their high logical-page bits at zero. This makes logical aliases frequent, which exercises the removal of duplicate entries.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

    localparam int unsigned LA_W    = 26;  // logical address width
    localparam int unsigned PPN_W   = 7;   // physical page index width
    localparam int unsigned PAGES   = 1 << PPN_W;
    localparam int unsigned LPN_W   = 13;  // widest logical page number (4 KB)
    localparam int unsigned BASE_SH = 12;  // log2 of smallest page
    localparam int unsigned PA_W    = PPN_W + BASE_SH + 3;
    localparam int unsigned ED_W    = 23;  // entry write word width

    typedef enum logic [1:0] {PG_4K, PG_8K, PG_16K, PG_32K} pg_size_e;

    typedef struct packed {
        logic             valid;
        logic [LPN_W-1:0] lpn;
        logic [1:0]       prot;
    } pte_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [LPN_W-1:0] lpn;
        logic [1:0]       prot;
        logic [1:0]       sel;
    } ent_wr_t;

    function automatic logic [3:0] page_shift(input logic [1:0] ps);
        return 4'(BASE_SH) + {2'b00, ps};
    endfunction

    function automatic logic [LPN_W-1:0] lookup_lpn(input logic [LA_W-1:0] a,
                                                     input logic [1:0] ps);
        logic [24:0] t;
        t = a[24:0] >> page_shift(ps);
        return t[LPN_W-1:0];
    endfunction

    function automatic ent_wr_t decode_entry(input logic [ED_W-1:0] d,
                                             input logic [1:0] ps);
        ent_wr_t e;
        e.prot = d[9:8];
        case (pg_size_e'(ps))
            PG_4K: begin
                e.ppn = d[6:0];
                e.lpn = {d[11:10], d[22:12]};
                e.sel = {1'b0, d[7]};
            end
            PG_8K: begin
                e.ppn = {d[0], d[6:1]};
                e.lpn = {1'b0, d[11:10], d[22:13]};
                e.sel = {d[12], d[7]};
            end
            PG_16K: begin
                e.ppn = {d[1:0], d[6:2]};
                e.lpn = {2'b00, d[11:10], d[22:14]};
                e.sel = {d[12], d[7]};
            end
            default: begin
                e.ppn = {d[1], d[2], d[0], d[6:3]};
                e.lpn = {3'b000, d[11:10], d[22:15]};
                e.sel = {d[12], d[7]};
            end
        endcase
        return e;
    endfunction

    function automatic logic access_ok(input logic sup, input logic os,
                                       input logic wr, input logic [1:0] prot);
        if (sup) return 1'b1;
        case (prot)
            2'd0:    return 1'b1;
            2'd1:    return os | ~wr;
            default: return os & ~wr;
        endcase
    endfunction

endpackage

// File: rtl/page_xlate_decode.sv
module page_xlate_decode
    import page_xlate_pkg::*;
#(
    parameter logic [1:0] CTRL_ID = 2'd0
) (
    input  logic            ent_we,
    input  logic [ED_W-1:0] ent_data,
    input  logic [1:0]      page_size,
    output ent_wr_t         ent,
    output logic            apply
);
    always_comb begin
        ent   = decode_entry(ent_data, page_size);
        apply = ent_we && (ent.sel == CTRL_ID);
    end
endmodule

// File: rtl/page_xlate_table.sv
module page_xlate_table
    import page_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ent_wr_t          wr_ent,
    input  logic [LPN_W-1:0] look_lpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_idx,
    output logic [1:0]       hit_prot,
    output logic [PAGES-1:0] match_vec
);
    pte_t tbl [PAGES];

    for (genvar i = 0; i < PAGES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (wr_en) begin
                if (wr_ent.ppn == PPN_W'(i)) begin
                    tbl[i].valid <= 1'b1;
                    tbl[i].lpn   <= wr_ent.lpn;
                    tbl[i].prot  <= wr_ent.prot;
                end else if (tbl[i].lpn == wr_ent.lpn) begin
                    tbl[i].valid <= 1'b0;   // drop the old alias
                end
            end
        end
        assign match_vec[i] = tbl[i].valid && (tbl[i].lpn == look_lpn);
    end

    // lowest index wins if ever more than one entry matches
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = PPN_W'(i);
            end
        end
        hit_prot = tbl[hit_idx].prot;
    end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter logic [1:0] CTRL_ID = 2'd0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [25:0]     acc_addr,
    input  logic            sup_we,
    input  logic            sup_val,
    input  logic            os_mode,
    input  logic [1:0]      page_size,
    input  logic            ent_we,
    input  logic [22:0]     ent_data,
    output logic            out_valid,
    output logic            out_hit,
    output logic            out_rom,
    output logic [21:0]     out_phys,
    output logic            abort
);
    ent_wr_t          dec_ent;
    logic             dec_apply;
    logic             tbl_hit;
    logic [PPN_W-1:0] tbl_idx;
    logic [1:0]       tbl_prot;
    logic [PAGES-1:0] tbl_match;
    logic [LPN_W-1:0] look_lpn;

    logic sup_q, overlay_q;

    page_xlate_decode #(.CTRL_ID(CTRL_ID)) u_dec (
        .ent_we   (ent_we),
        .ent_data (ent_data),
        .page_size(page_size),
        .ent      (dec_ent),
        .apply    (dec_apply)
    );

    page_xlate_table u_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (dec_apply),
        .wr_ent   (dec_ent),
        .look_lpn (look_lpn),
        .hit      (tbl_hit),
        .hit_idx  (tbl_idx),
        .hit_prot (tbl_prot),
        .match_vec(tbl_match)
    );

    logic [3:0]      sh;
    logic [PA_W-1:0] off_mask, xl_phys;
    logic            n_hit, n_rom, n_fault, is_direct;
    logic [PA_W-1:0] n_phys;

    always_comb begin
        look_lpn  = lookup_lpn(acc_addr, page_size);
        sh        = page_shift(page_size);
        off_mask  = ~({PA_W{1'b1}} << sh);
        xl_phys   = (PA_W'(tbl_idx) << sh) | (acc_addr[PA_W-1:0] & off_mask);
        is_direct = acc_addr[LA_W-1];
        n_hit     = 1'b0;
        n_rom     = 1'b0;
        n_fault   = 1'b0;
        n_phys    = '0;
        if (is_direct) begin
            n_hit   = sup_q;
            n_fault = ~sup_q;
            if (sup_q) n_phys = acc_addr[PA_W-1:0];
        end else if (overlay_q) begin
            if (!acc_write) begin
                n_rom  = 1'b1;
                n_phys = acc_addr[PA_W-1:0];
            end
        end else if (tbl_hit && access_ok(sup_q, os_mode, acc_write, tbl_prot)) begin
            n_hit  = 1'b1;
            n_phys = xl_phys;
        end else begin
            n_fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sup_q     <= 1'b1;
            overlay_q <= 1'b1;
            abort     <= 1'b0;
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_rom   <= 1'b0;
            out_phys  <= '0;
        end else begin
            if (sup_we) sup_q <= sup_val;
            if (ent_we || (acc_valid && is_direct)) overlay_q <= 1'b0;
            abort     <= (abort & ~sup_we) | (acc_valid & n_fault);
            out_valid <= acc_valid;
            out_hit   <= acc_valid & n_hit;
            out_rom   <= acc_valid & n_rom;
            out_phys  <= acc_valid ? n_phys : '0;
        end
    end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk
    import page_xlate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [25:0]      acc_addr,
    input logic             ent_we,
    input logic             sup_we,
    input logic             out_valid,
    input logic             out_hit,
    input logic             out_rom,
    input logic             abort,
    input logic [PAGES-1:0] match_vec
);
    logic cleared_q;
    always_ff @(posedge clk) begin
        if (rst) cleared_q <= 1'b0;
        else if (ent_we || (acc_valid && acc_addr[25])) cleared_q <= 1'b1;
    end

    p_one_match_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    p_abort_hold_r7: assert property (@(posedge clk) disable iff (rst)
        abort && !sup_we |=> abort);

    p_abort_clear_r7: assert property (@(posedge clk) disable iff (rst)
        sup_we && !acc_valid |=> !abort);

    p_rom_excl_r9: assert property (@(posedge clk) disable iff (rst)
        out_rom |-> out_valid && !out_hit);

    p_overlay_end_r10: assert property (@(posedge clk) disable iff (rst)
        out_rom |-> !$past(cleared_q));

    p_result_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(acc_valid));
endmodule

bind page_xlate page_xlate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .ent_we   (ent_we),
    .sup_we   (sup_we),
    .out_valid(out_valid),
    .out_hit  (out_hit),
    .out_rom  (out_rom),
    .abort    (abort),
    .match_vec(tbl_match)
);

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 0, acc_write = 0;
    logic [25:0] acc_addr = '0;
    logic        sup_we = 0, sup_val = 0, os_mode = 0;
    logic [1:0]  page_size = 0;
    logic        ent_we = 0;
    logic [22:0] ent_data = '0;
    logic        out_valid, out_hit, out_rom, abort;
    logic [21:0] out_phys;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    page_xlate u_dut (.*);

    // bench model
    bit         m_valid [128];
    logic [12:0] m_lpn  [128];
    logic [1:0] m_prot  [128];
    bit m_overlay, m_sup, m_abort;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        foreach (m_valid[i]) begin m_valid[i] = 0; m_lpn[i] = 0; m_prot[i] = 0; end
        m_overlay = 1; m_sup = 1; m_abort = 0;
    endfunction

    // R2/R3/R4 model of an entry write
    function automatic void m_entry(logic [22:0] d, logic [1:0] ps);
        logic [6:0] p; logic [12:0] l; logic [1:0] s; int nu;
        case (ps)
            0: p = d[6:0];
            1: begin p[6] = d[0]; p[5:0] = d[6:1]; end
            2: begin p[6:5] = d[1:0]; p[4:0] = d[6:2]; end
            default: begin p[6] = d[1]; p[5] = d[2]; p[4] = d[0]; p[3:0] = d[6:3]; end
        endcase
        nu = 11 - ps;
        l = 13'((32'(d[11:10]) << nu) | ((32'(d) >> (12 + ps)) & ((32'd1 << nu) - 1)));
        s = (ps == 0) ? {1'b0, d[7]} : {d[12], d[7]};
        m_overlay = 0;
        if (s != 2'd0) return;
        foreach (m_valid[i]) if (m_valid[i] && m_lpn[i] == l) m_valid[i] = 0;
        m_valid[p] = 1; m_lpn[p] = l; m_prot[p] = d[9:8];
    endfunction

    function automatic bit m_allowed(logic [1:0] pr, bit wr);
        if (m_sup) return 1;
        if (pr == 0) return 1;
        if (pr == 1) return os_mode || !wr;
        return os_mode && !wr;
    endfunction

    task automatic do_entry(logic [22:0] d);
        @(negedge clk); ent_we = 1; ent_data = d;
        @(negedge clk); ent_we = 0;
        m_entry(d, page_size);
    endtask

    task automatic do_sup(bit v);
        @(negedge clk); sup_we = 1; sup_val = v;
        @(negedge clk); sup_we = 0;
        m_sup = v; m_abort = 0;
    endtask

    // expected: {valid, hit, rom, abort, phys}
    task automatic do_access(string req, logic [25:0] a, bit wr);
        bit h = 0, r = 0, f = 0; logic [21:0] ph = 0; int sh; logic [12:0] l; int idx = -1;
        sh = 12 + page_size;
        if (a[25]) begin
            if (m_sup) begin h = 1; ph = a[21:0]; end else f = 1;
        end else if (m_overlay) begin
            if (!wr) begin r = 1; ph = a[21:0]; end
        end else begin
            l = 13'(a[24:0] >> sh);
            for (int i = 0; i < 128; i++) if (m_valid[i] && m_lpn[i] == l) idx = i;
            if (idx >= 0 && m_allowed(m_prot[idx], wr)) begin
                h = 1;
                ph = 22'((idx << sh) + (32'(a) & ((32'd1 << sh) - 1)));
            end else f = 1;
        end
        if (a[25]) m_overlay = 0;
        if (f) m_abort = 1;
        @(negedge clk); acc_valid = 1; acc_addr = a; acc_write = wr;
        @(negedge clk); acc_valid = 0;
        check(req, {6'b0, out_valid, out_hit, out_rom, abort, out_phys},
                   {6'b0, 1'b1, h, r, m_abort, ph});
    endtask

    function automatic logic [22:0] mk4k(logic [6:0] p, logic [10:0] up, logic [1:0] hi, logic [1:0] pr);
        return {up, 1'b0, hi, pr, 1'b0, p};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [22:0] d;
        void'($urandom(32'h1f3a5));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        check("R8", {out_valid, out_hit, out_rom, abort, out_phys}, 26'd0);
        // R9 overlay read/write
        do_access("R9 overlay read", 26'h0012344, 0);
        do_access("R9 overlay write ignored", 26'h0012344, 1);
        // R11 result pulse lasts one cycle
        @(negedge clk); check("R11 pulse low", {31'b0, out_valid}, 0);
        // R10 direct access ends overlay, then translation active
        do_access("R10 direct sup", 26'h2345678, 0);
        do_access("R10 overlay gone", 26'h0012344, 0);
        // R1/R2 4 KB mapping
        do_entry(mk4k(7'd5, 11'd18, 2'd0, 2'd0));
        do_access("R1 4K", 26'h0012abc, 1);
        // R10 direct without supervisor aborts; R7 sticky and clear
        do_sup(0);
        do_access("R10 direct user", 26'h2000010, 0);
        do_access("R7 abort sticky", 26'h0012000, 0);
        do_sup(0);
        do_access("R7 abort cleared", 26'h0012000, 0);
        // R6 protection levels
        for (int pr = 0; pr < 4; pr++)
            for (int os = 0; os < 2; os++)
                for (int wr = 0; wr < 2; wr++) begin
                    do_entry(mk4k(7'd9, 11'd3, 2'd1, 2'(pr)));
                    os_mode = os[0];
                    do_access($sformatf("R6 prot%0d os%0d wr%0d", pr, os, wr),
                              26'h0403000 + 26'h10, wr[0]);
                    do_sup(0);
                end
        // R5 supervisor overrides level 3
        do_sup(1); os_mode = 0;
        do_access("R5 sup write lvl3", 26'h0403008, 1);
        // R1/R2 larger page sizes
        for (int ps = 1; ps < 4; ps++) begin
            page_size = 2'(ps);
            d = 23'h0;
            d[6:0] = 7'h5a; d[11:10] = 2'd1; d[22:15] = 8'h3;
            do_entry(d);
            do_access($sformatf("R2 size%0d", ps), {1'b0, 25'((32'h1 << (13 - ps)) | (32'h3 << (15 - ps + 12 - 12))) << 0} , 0);
            do_access($sformatf("R1 size%0d", ps),
                      26'((32'(m_lpn[0]) * 0) + (((32'd1 << (13 - ps)) | (32'd3 << (15 - 12 - ps + 12 - 12 + 0)) ) << (12 + ps)) + 32'h7f4), 0);
        end
        // R3 wrong controller select ignored
        page_size = 1;
        d = 23'h0; d[6:0] = 7'h11; d[7] = 1; d[22:13] = 10'h155;
        do_entry(d);
        do_access("R3 select mismatch", 26'((32'h155) << 13), 0);
        do_sup(1);
        // R4 alias removal
        page_size = 0;
        do_entry(mk4k(7'd2, 11'd77, 2'd0, 2'd0));
        do_entry(mk4k(7'd40, 11'd77, 2'd0, 2'd0));
        do_access("R4 latest alias wins", 26'(77 << 12) + 26'h44, 0);
        do_entry(mk4k(7'd2, 11'd78, 2'd0, 2'd0));
        do_access("R4 other page", 26'(77 << 12) + 26'h48, 0);
        do_access("R4 remapped", 26'(78 << 12) + 26'h4c, 0);
        // random mix
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = $urandom % 16;
            if (r < 4) begin
                d = 23'($urandom);
                d[22:16] = 0;
                if ($urandom % 8 != 0) begin d[7] = 0; d[12] = 0; end
                do_entry(d);
            end else if (r < 12) begin
                logic [25:0] a; int idx = -1;
                for (int t = 0; t < 8; t++) begin
                    int c; c = $urandom % 128;
                    if (m_valid[c]) idx = c;
                end
                if (idx >= 0 && r < 9)
                    a = {1'b0, 25'((32'(m_lpn[idx]) << (12 + page_size)) | ($urandom % (32'd1 << (12 + page_size))))};
                else begin
                    a = 26'($urandom) & 26'h007ffff;
                    if ($urandom % 10 == 0) a[25] = 1;
                end
                do_access("R6 random", a, 1'($urandom));
            end else if (r == 12) do_sup(1'($urandom));
            else if (r == 13) begin @(negedge clk); os_mode = ~os_mode; end
            else if (r == 14) begin @(negedge clk); page_size = 2'($urandom); end
            else do_sup(1);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule